// File: doc/BRIEF.md
# Serial Line Transmitter with Holding Register

The block turns bytes from a host into asynchronous serial frames on a single output line. The path has two stages. The host loads a holding register through a write strobe and an 8-bit data bus. A shift register then serializes the byte. A flag tells the host when the holding register can take another byte, so the host can queue the next byte while the current one is still on the line.

Line timing comes from a bit-time tick supplied from outside. The tick is a one-cycle pulse in the system clock domain. The line changes only on clock edges where the tick is high, so each line bit lasts exactly one tick interval. A frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. When a byte is already waiting at the end of a stop bit, its start bit follows at once.

Top module: `ser_tx_line`

## Requirements
- R1: While no frame is in progress, `tx_o` is 1.
- R2: When a byte is pending and the shifter is idle, the next tick edge drives `tx_o` to 0 (the start bit). The start bit lasts exactly one tick interval.
- R3: The eight data bits follow the start bit, one per tick interval, with bit 0 first and bit 7 last.
- R4: After bit 7, `tx_o` is 1 for at least one tick interval (the stop bit).
- R5: A write (`wr_en_i` high at a clock edge) stores `wr_data_i` and clears `hold_empty_o` to 0 after that edge. This also holds when the same edge moves the previous byte into the shifter.
- R6: `hold_empty_o` returns to 1 at the same edge that drives the start bit of the byte taken from the holding register. This happens while the frame is still in progress.
- R7: When `rst_ni` is low, `tx_o` is 1 and `hold_empty_o` is 1 at once, without waiting for a clock edge. This holds even in the middle of a frame.
- R8: `tx_o` and the byte transfer change only on clock edges where `bit_tick_i` is 1. Between ticks the line holds its value.
- R9: If a byte is pending when the stop bit ends, the next tick edge starts the new frame directly, with no idle interval in between.
- R10: A write made while `hold_empty_o` is 0 replaces the pending byte. Only the latest byte is sent, and no error is signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | 8 | Byte to load into the holding register |
| bit_tick_i | input | 1 | One-cycle pulse that marks each bit-time boundary |
| tx_o | output | 1 | Serial line output |
| hold_empty_o | output | 1 | 1 when the holding register has no pending byte |

## Verification
Most wrong internal states show up on `tx_o` within one tick interval:
- A wrong shift position or a wrong bit counter gives a wrong data bit, or moves the stop bit one interval early or late.
- A shifter stuck outside idle leaves the line low, or sends a stray frame on the next tick.

A wrong holding-register state shows up on `hold_empty_o` right after the write or the start-bit edge. It can also show up one frame later, when a byte is dropped or sent twice. The back-to-back and overwrite sequences compare whole runs of line bits, tick by tick, so a missing or extra idle interval is also seen at the port.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q;

  // A write wins over a same-cycle take: the old byte leaves, the new one stays pending.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_en_i) begin
      data_q  <= wr_data_i;
      empty_q <= 1'b0;
    end else if (take_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tx_q;
  logic              can_load;

  assign can_load = (state_q == ST_IDLE) || (state_q == ST_STOP);
  assign take_o   = tick_i && pending_i && can_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      tx_q    <= 1'b1;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE, ST_STOP: begin
          if (pending_i) begin
            shreg_q <= data_i;
            tx_q    <= 1'b0;
            state_q <= ST_START;
          end else begin
            tx_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_START: begin
          tx_q    <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt_q == LAST_IDX) begin
            tx_q    <= 1'b1;
            state_q <= ST_STOP;
          end else begin
            tx_q    <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign tx_o   = tx_q;
endmodule

// File: rtl/ser_tx_line.sv
module ser_tx_line #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit_tick_i,
  output logic              tx_o,
  output logic              hold_empty_o
);
  logic [DATA_W-1:0] hold_data;
  logic              hold_empty;
  logic              take;
  logic              line_busy;

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (hold_data),
    .empty_o   (hold_empty)
  );

  ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bit_tick_i),
    .pending_i (!hold_empty),
    .data_i    (hold_data),
    .take_o    (take),
    .busy_o    (line_busy),
    .tx_o      (tx_o)
  );

  assign hold_empty_o = hold_empty;
endmodule

// File: rtl/ser_tx_line_chk.sv
module ser_tx_line_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic bit_tick_i,
  input logic tx_o,
  input logic hold_empty_o,
  input logic busy_i
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> tx_o); // R1

  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !hold_empty_o); // R5

  AST_EMPTY_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $rose(hold_empty_o)) |-> (!tx_o && busy_i)); // R6

  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(bit_tick_i)) |-> $stable(tx_o)); // R8

  AST_TAKE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $rose(hold_empty_o)) |-> $past(bit_tick_i)); // R8
endmodule

bind ser_tx_line ser_tx_line_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .bit_tick_i   (bit_tick_i),
  .tx_o         (tx_o),
  .hold_empty_o (hold_empty_o),
  .busy_i       (line_busy)
);

// File: tb/ser_tx_line_test.sv
module ser_tx_line_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       bit_tick_i = 1'b0;
  logic       tx_o;
  logic       hold_empty_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  ser_tx_line uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .bit_tick_i   (bit_tick_i),
    .tx_o         (tx_o),
    .hold_empty_o (hold_empty_o)
  );

  always #10 clk_i = ~clk_i;

  // stimulus byte and expected line bits, bit 0 goes out first
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'hA5, 1'b1, 8'hA5, 1'b0},
    {8'h00, 1'b1, 8'h00, 1'b0},
    {8'hFF, 1'b1, 8'hFF, 1'b0},
    {8'h01, 1'b1, 8'h01, 1'b0},
    {8'h80, 1'b1, 8'h80, 1'b0},
    {8'h3C, 1'b1, 8'h3C, 1'b0}
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic write_byte(input logic [7:0] b);
    wr_en_i = 1'b1;
    wr_data_i = b;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tick;
    bit_tick_i = 1'b1;
    @(negedge clk_i);
    bit_tick_i = 1'b0;
  endtask

  task automatic collect(input int n, output logic [19:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      tick();
      bits[i] = tx_o;
    end
  endtask

  initial begin
    logic [19:0] got;
    idle_cycles(3);
    chk("R7 reset line", 20'(tx_o), 20'd1);
    chk("R7 reset empty", 20'(hold_empty_o), 20'd1);
    rst_ni = 1'b1;
    idle_cycles(2);

    // R1: ticks with nothing pending keep the line high
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1 idle high", 20'(tx_o), 20'd1);
    end

    for (int v = 0; v < NVEC; v++) begin
      write_byte(VEC[v][17:10]);
      chk("R5 empty cleared", 20'(hold_empty_o), 20'd0);
      idle_cycles(4);
      chk("R8 no tick no start", 20'(tx_o), 20'd1);
      tick();
      chk("R2 start bit", 20'(tx_o), 20'd0);
      chk("R6 empty on start", 20'(hold_empty_o), 20'd1);
      collect(9, got);
      chk("R3 R4 frame bits", {10'd0, got[8:0], 1'b0}, {10'd0, VEC[v][9:0]});
      tick();
      chk("R1 idle after stop", 20'(tx_o), 20'd1);
    end

    // R9: byte queued during a frame follows directly after the stop bit
    write_byte(8'h5A);
    tick();
    write_byte(8'hC3);
    chk("R5 queued write", 20'(hold_empty_o), 20'd0);
    idle_cycles(2);
    chk("R8 hold between ticks", 20'(tx_o), 20'd0);
    collect(9, got);
    chk("R9 pending kept to stop", 20'(hold_empty_o), 20'd0);
    collect(10, got);
    chk("R9 second frame no gap", 20'(got[9:0]), 20'({1'b1, 8'hC3, 1'b0}));
    tick();
    chk("R1 idle after pair", 20'(tx_o), 20'd1);

    // R10: second write replaces the pending byte
    write_byte(8'h11);
    write_byte(8'h22);
    collect(10, got);
    chk("R10 latest byte sent", 20'(got[9:0]), 20'({1'b1, 8'h22, 1'b0}));
    tick();
    chk("R10 single frame", 20'(tx_o), 20'd1);
    chk("R10 empty after", 20'(hold_empty_o), 20'd1);

    // R5: write on the same edge as the transfer keeps the new byte pending
    write_byte(8'h77);
    wr_en_i = 1'b1;
    wr_data_i = 8'h99;
    bit_tick_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    bit_tick_i = 1'b0;
    chk("R2 start with write", 20'(tx_o), 20'd0);
    chk("R5 write beats take", 20'(hold_empty_o), 20'd0);
    collect(19, got);
    chk("R9 both frames", {got[18:0], 1'b0}, {1'b1, 8'h99, 1'b0, 1'b1, 8'h77, 1'b0});
    tick();
    chk("R1 idle end", 20'(tx_o), 20'd1);

    // R7: reset in mid-frame acts at once
    write_byte(8'h00);
    collect(3, got);
    write_byte(8'h44);
    #3 rst_ni = 1'b0;
    #1;
    chk("R7 async line", 20'(tx_o), 20'd1);
    chk("R7 async empty", 20'(hold_empty_o), 20'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk("R7 nothing left", 20'(tx_o), 20'd1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule